// File: doc/BRIEF.md
# Legacy Video Cycle Router

This block sits in a bridge that has a primary downstream graphics port and a secondary peer bus. For every bus cycle offered to it, it decides two things: whether the bridge claims the cycle, and which bus receives it. Each cycle is described by its address, its space (memory or I/O), its direction and the bus it came from. Two configuration inputs control the decision. The first turns on VGA forwarding to the graphics port. The second reports that a monochrome adapter sits on the peer bus. When both are set, the monochrome sub-ranges are taken out of the VGA window. A monochrome card on the peer bus keeps those sub-ranges, and every other legacy video cycle goes to the graphics port.

A request is presented for one clock with `req_valid`. The decision appears on the response outputs on the next clock. A small controller sequences the response.

- **States:** `ST_IDLE` (no response shown) and `ST_ISSUE` (response valid).
- **Transitions:**
  - `IDLE_TO_ISSUE` happens on a valid request.
  - `ISSUE_HOLD` happens on a back-to-back request.
  - `ISSUE_TO_IDLE` happens when no request follows.
  - `IDLE_WAIT` happens when the block stays idle.

The configuration pair selects one of three routing modes: `MODE_ALL_PEER`, `MODE_ALL_GFX` and `MODE_MONO_SPLIT`.

Top module: `legacy_video_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rsp_valid` and `rsp_claim` are 0 and `rsp_target` is 2'b00.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high, and 0 otherwise. While `rsp_valid` is 0, `rsp_claim` is 0 and `rsp_target` is 2'b00. Configuration and request inputs are sampled in the request cycle.
- R3: A memory cycle (`req_is_io`=0) is in the decode window only when the full `ADDR_W`-bit address lies from 0x0A0000 to 0x0BFFFF inclusive.
- R4: For an I/O cycle (`req_is_io`=1), only address bits [9:0] are decoded, so any value of the upper bits aliases. The window is 0x3B0–0x3BB and 0x3C0–0x3DF, plus the monochrome I/O ports of R10.
- R5: With `cfg_vga_en`=0, host cycles (`req_origin`=2'b00) in the window are claimed with `rsp_target`=2'b01 (peer bus), whatever `cfg_mono_present` is. Peer-bus master cycles (`req_origin`=2'b01) are never claimed.
- R6: With `cfg_vga_en`=1 and `cfg_mono_present`=0:
  - Host cycles in the window are claimed with `rsp_target`=2'b10 (graphics port).
  - Peer-bus master writes (`req_is_write`=1) in the window are claimed with target 2'b10.
  - Peer-bus master reads are never claimed, in any mode.
- R7: With both configuration bits at 1, host cycles that hit a monochrome range are claimed with target 2'b01. Other host window cycles are claimed with target 2'b10.
- R8: With both configuration bits at 1, peer-bus master writes in the window but outside the monochrome ranges are claimed with target 2'b10. Master cycles from the peer bus or the graphics port that hit a monochrome range are not claimed.
- R9: Cycles from the graphics port (`req_origin`=2'b10) and from the reserved origin code 2'b11 are never claimed.
- R10: The monochrome ranges are memory 0x0B0000–0x0B7FFF and I/O ports 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA and 0x3BF, using bits [9:0] for I/O.
- R11: Every unclaimed response, including a host cycle outside the window, carries the default target code 2'b00. Every claimed response carries 2'b01 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vga_en | input | 1 | Forward VGA cycles to the graphics port |
| cfg_mono_present | input | 1 | Monochrome adapter present on the peer bus |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | ADDR_W | Cycle address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_origin | input | 2 | 00 host, 01 peer master, 10 graphics master, 11 reserved |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_claim | output | 1 | Bridge claims the cycle |
| rsp_target | output | 2 | 00 none/default, 01 peer bus, 10 graphics port |

## Verification
The bench builds the block with its defaults: `ADDR_W`=32 and `IO_W`=10.

The full 32-bit address lets memory cycles that carry nonzero upper bits fall outside the window. The 10-bit I/O decode leaves bits 10 and up free, so the random I/O addresses set those bits to reach the alias behaviour.

Random gaps between requests drive both controller paths, back-to-back and idle. Directed cases sit on each range edge and on the monochrome port 0x3BF, which lies outside the plain VGA port window.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

    typedef enum logic [1:0] {
        ORG_HOST = 2'b00,
        ORG_PEER = 2'b01,
        ORG_GFX  = 2'b10,
        ORG_RSVD = 2'b11
    } origin_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_PEER = 2'b01,
        RT_GFX  = 2'b10,
        RT_BAD  = 2'b11
    } route_t;

    typedef enum logic [1:0] {
        MODE_ALL_PEER,
        MODE_ALL_GFX,
        MODE_MONO_SPLIT
    } mode_t;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } rsp_state_t;

    typedef struct packed {
        logic   claim;
        route_t target;
    } decision_t;

endpackage

// File: rtl/lvr_range_match.sv
module lvr_range_match #(
    parameter int          ADDR_W     = 32,
    parameter int          IO_W       = 10,
    parameter int unsigned MEM_WIN_LO = 32'h000A_0000,
    parameter int unsigned MEM_WIN_HI = 32'h000B_FFFF,
    parameter int unsigned MEM_MDA_LO = 32'h000B_0000,
    parameter int unsigned MEM_MDA_HI = 32'h000B_7FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic              win_hit,
    output logic              mono_hit
);

    localparam int N_MONO_PORTS = 6;
    localparam int N_IO_SPANS   = 2;
    localparam logic [11:0] MONO_PORTS [N_MONO_PORTS] =
        '{12'h3B4, 12'h3B5, 12'h3B8, 12'h3B9, 12'h3BA, 12'h3BF};
    localparam logic [11:0] SPAN_LO [N_IO_SPANS] = '{12'h3B0, 12'h3C0};
    localparam logic [11:0] SPAN_HI [N_IO_SPANS] = '{12'h3BB, 12'h3DF};

    logic [IO_W-1:0]         io_lo;
    logic [N_MONO_PORTS-1:0] port_eq;
    logic [N_IO_SPANS-1:0]   span_in;
    logic                    mem_win, mem_mono, io_win, io_mono;

    assign io_lo = addr[IO_W-1:0];

    for (genvar g = 0; g < N_MONO_PORTS; g++) begin : g_mono_port
        assign port_eq[g] = (io_lo == IO_W'(MONO_PORTS[g]));
    end

    for (genvar s = 0; s < N_IO_SPANS; s++) begin : g_io_span
        assign span_in[s] = (io_lo >= IO_W'(SPAN_LO[s])) &&
                            (io_lo <= IO_W'(SPAN_HI[s]));
    end

    always_comb begin
        mem_win  = (addr >= ADDR_W'(MEM_WIN_LO)) && (addr <= ADDR_W'(MEM_WIN_HI));
        mem_mono = (addr >= ADDR_W'(MEM_MDA_LO)) && (addr <= ADDR_W'(MEM_MDA_HI));
        io_mono  = |port_eq;
        io_win   = (|span_in) || io_mono;
        if (is_io) begin
            win_hit  = io_win;
            mono_hit = io_mono;
        end else begin
            win_hit  = mem_win;
            mono_hit = mem_mono;
        end
    end

endmodule

// File: rtl/lvr_route_table.sv
module lvr_route_table
    import lvr_pkg::*;
(
    input  logic      cfg_vga_en,
    input  logic      cfg_mono_present,
    input  logic      win_hit,
    input  logic      mono_hit,
    input  origin_t   origin,
    input  logic      is_write,
    output decision_t decision
);

    mode_t mode;
    logic  mono_carved;

    always_comb begin
        if (!cfg_vga_en)            mode = MODE_ALL_PEER;
        else if (!cfg_mono_present) mode = MODE_ALL_GFX;
        else                        mode = MODE_MONO_SPLIT;
    end

    assign mono_carved = (mode == MODE_MONO_SPLIT) && mono_hit;

    always_comb begin
        decision.claim  = 1'b0;
        decision.target = RT_NONE;
        if (win_hit) begin
            unique case (origin)
                ORG_HOST: begin
                    decision.claim = 1'b1;
                    unique case (mode)
                        MODE_ALL_PEER:   decision.target = RT_PEER;
                        MODE_ALL_GFX:    decision.target = RT_GFX;
                        MODE_MONO_SPLIT: decision.target = mono_carved ? RT_PEER : RT_GFX;
                        default:         decision.target = RT_NONE;
                    endcase
                end
                ORG_PEER: begin
                    if (is_write && (mode != MODE_ALL_PEER) && !mono_carved) begin
                        decision.claim  = 1'b1;
                        decision.target = RT_GFX;
                    end
                end
                ORG_GFX, ORG_RSVD: begin
                    decision.claim  = 1'b0;
                    decision.target = RT_NONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/legacy_video_router.sv
module legacy_video_router
    import lvr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vga_en,
    input  logic              cfg_mono_present,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              req_is_write,
    input  logic [1:0]        req_origin,
    output logic              rsp_valid,
    output logic              rsp_claim,
    output logic [1:0]        rsp_target
);

    rsp_state_t state_q, state_d;
    decision_t  dec_now, dec_q;
    logic       win_hit, mono_hit;

    lvr_range_match #(
        .ADDR_W (ADDR_W),
        .IO_W   (IO_W)
    ) u_match (
        .addr     (req_addr),
        .is_io    (req_is_io),
        .win_hit  (win_hit),
        .mono_hit (mono_hit)
    );

    lvr_route_table u_table (
        .cfg_vga_en       (cfg_vga_en),
        .cfg_mono_present (cfg_mono_present),
        .win_hit          (win_hit),
        .mono_hit         (mono_hit),
        .origin           (origin_t'(req_origin)),
        .is_write         (req_is_write),
        .decision         (dec_now)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = req_valid ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dec_q   <= '{claim: 1'b0, target: RT_NONE};
        end else begin
            state_q <= state_d;
            if (req_valid) dec_q <= dec_now;
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_claim  = 1'b0;
        rsp_target = RT_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                rsp_valid  = 1'b1;
                rsp_claim  = dec_q.claim;
                rsp_target = dec_q.target;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lvr_checker.sv
module lvr_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_vga_en,
    input logic              cfg_mono_present,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_is_io,
    input logic              req_is_write,
    input logic [1:0]        req_origin,
    input logic              rsp_valid,
    input logic              rsp_claim,
    input logic [1:0]        rsp_target
);

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_quiet_when_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_claim && rsp_target == 2'b00));

    p_claim_has_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_claim |-> (rsp_target == 2'b01 || rsp_target == 2'b10));

    p_unclaimed_default_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claim) |-> rsp_target == 2'b00);

    p_gfx_origin_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_origin[1]) |=> !rsp_claim);

    p_peer_read_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_origin == 2'b01 && !req_is_write) |=> !rsp_claim);

    p_vga_off_no_gfx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_vga_en) |=> rsp_target != 2'b10);

    p_peer_claim_to_gfx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_origin == 2'b01) |=> (!rsp_claim || rsp_target == 2'b10));

    p_host_mono_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_origin == 2'b00 && cfg_vga_en && cfg_mono_present
         && !req_is_io && req_addr >= ADDR_W'(32'h000B_0000)
         && req_addr <= ADDR_W'(32'h000B_7FFF)) |=> (rsp_claim && rsp_target == 2'b01));

endmodule

bind legacy_video_router lvr_checker #(.ADDR_W(ADDR_W)) u_lvr_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_vga_en       (cfg_vga_en),
    .cfg_mono_present (cfg_mono_present),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_is_io        (req_is_io),
    .req_is_write     (req_is_write),
    .req_origin       (req_origin),
    .rsp_valid        (rsp_valid),
    .rsp_claim        (rsp_claim),
    .rsp_target       (rsp_target)
);

// File: tb/tb_legacy_video_router.sv
module tb_legacy_video_router;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_vga_en = 1'b0;
    logic              cfg_mono_present = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_is_io = 1'b0;
    logic              req_is_write = 1'b0;
    logic [1:0]        req_origin = 2'b00;
    logic              rsp_valid;
    logic              rsp_claim;
    logic [1:0]        rsp_target;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    legacy_video_router #(.ADDR_W(ADDR_W), .IO_W(10)) dut (
        .clk, .rst_n, .cfg_vga_en, .cfg_mono_present, .req_valid, .req_addr,
        .req_is_io, .req_is_write, .req_origin, .rsp_valid, .rsp_claim, .rsp_target
    );

    function automatic logic is_mono(logic [31:0] a, logic io);
        logic [9:0] p;
        p = a[9:0];
        if (io) return p == 10'h3B4 || p == 10'h3B5 || p == 10'h3B8 ||
                       p == 10'h3B9 || p == 10'h3BA || p == 10'h3BF;
        return a >= 32'h000B_0000 && a <= 32'h000B_7FFF;
    endfunction

    function automatic logic in_window(logic [31:0] a, logic io);
        logic [9:0] p;
        p = a[9:0];
        if (io) return (p >= 10'h3B0 && p <= 10'h3BB) ||
                       (p >= 10'h3C0 && p <= 10'h3DF) || is_mono(a, io);
        return a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    endfunction

    // returns {claim, target}
    function automatic logic [2:0] expect_route(logic [31:0] a, logic io, logic wr,
                                                logic [1:0] org, logic ven, logic mono);
        logic carve;
        if (!in_window(a, io)) return 3'b000;
        carve = ven && mono && is_mono(a, io);
        case (org)
            2'b00:   return (!ven || carve) ? 3'b101 : 3'b110;
            2'b01:   return (wr && ven && !carve) ? 3'b110 : 3'b000;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual {valid,claim,target}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic send(logic [31:0] a, logic io, logic wr, logic [1:0] org,
                        logic ven, logic mono, string req);
        logic [2:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io; req_is_write = wr;
        req_origin = org; cfg_vga_en = ven; cfg_mono_present = mono;
        e = expect_route(a, io, wr, org, ven, mono);
        @(posedge clk);
        #5;
        check(req, {rsp_valid, rsp_claim, rsp_target}, {1'b1, e});
    endtask

    task automatic gap(string req);
        @(negedge clk);
        req_valid = 1'b0;
        req_origin = 2'b00;
        req_addr = 32'h000A_0000;
        @(posedge clk);
        #5;
        check(req, {rsp_valid, rsp_claim, rsp_target}, 4'b0000);
    endtask

    initial begin
        #(200000 * 20);
        n_fails++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fails, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset", {rsp_valid, rsp_claim, rsp_target}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R1 after reset", {rsp_valid, rsp_claim, rsp_target}, 4'b0000);

        // R3 memory window edges, all modes
        for (int m = 0; m < 4; m++) begin
            send(32'h0009_FFFF, 1'b0, 1'b1, 2'b00, m[1], m[0], "R3 below window");
            send(32'h000A_0000, 1'b0, 1'b1, 2'b00, m[1], m[0], "R3 low edge");
            send(32'h000B_FFFF, 1'b0, 1'b0, 2'b00, m[1], m[0], "R3 high edge");
            send(32'h000C_0000, 1'b0, 1'b0, 2'b00, m[1], m[0], "R3 above window R11");
            send(32'h100A_0000, 1'b0, 1'b0, 2'b00, m[1], m[0], "R3 upper bits set");
        end
        gap("R2 idle after burst");
        // R4 / R10 I/O edges and aliases
        send(32'h0000_03AF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 below 3B0");
        send(32'h0000_03B0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 3B0");
        send(32'h0000_03BC, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 3BC outside");
        send(32'h0000_03DF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 3DF");
        send(32'h0000_03E0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 3E0 outside");
        send(32'hABCD_FFC0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R4 alias of 3C0");
        send(32'h0000_07B4, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R10 R7 alias mono port");
        send(32'h0000_03BF, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R10 R7 port 3BF");
        send(32'h0000_03BB, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R7 3BB non-mono");
        // R5 / R6 / R8 / R9 direct
        send(32'h000A_8000, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, "R5 peer write vga off");
        send(32'h000A_8000, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, "R5 host vga off");
        send(32'h000A_8000, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, "R6 peer write");
        send(32'h000A_8000, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, "R6 peer read");
        send(32'h000B_7FFF, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, "R8 peer write mono");
        send(32'h000B_8000, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, "R8 peer write past mono");
        send(32'h000B_0000, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, "R8 R9 gfx master mono");
        send(32'h000A_0000, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, "R9 reserved origin");
        send(32'h000B_0000, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R7 host mono mem");
        gap("R2 idle");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            logic        io;
            int          pick;
            pick = int'($urandom_range(0, 9));
            io   = pick >= 5;
            case (pick)
                0, 1:    a = 32'h000A_0000 + $urandom_range(0, 32'h1_FFFF);
                2:       a = 32'h000B_0000 + $urandom_range(0, 32'h7FFF);
                3:       a = 32'h0009_FFF0 + $urandom_range(0, 32'h2_0020);
                4:       a = $urandom();
                5, 6:    a = {$urandom_range(0, 32'h3F_FFFF), 10'(10'h3B0 + $urandom_range(0, 15))};
                7:       a = {$urandom_range(0, 32'h3F_FFFF), 10'(10'h3C0 + $urandom_range(0, 32))};
                default: a = $urandom();
            endcase
            if ($urandom_range(0, 7) == 0) gap("R2 random gap");
            send(a, io, 1'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom()),
                 "R5 R6 R7 R8 R11 random");
        end
        gap("R2 final idle");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule